// File: doc/BRIEF.md
# Iterative Multiply Unit with High/Low Result Registers

This block multiplies two 32-bit operands, treating them either as two's-complement or as unsigned numbers, and leaves the 64-bit product split across two result registers: the upper half in `hi` and the lower half in `lo`. A processor core pulses `start` with the operands and the mode flag, then reads the two halves back later with its move-from-high and move-from-low instructions.

The product is built by a shift-add loop that consumes one multiplier bit per clock. A signed product is formed from the operand magnitudes, and the 64-bit result is negated in a final cycle when exactly one operand is negative. While the loop runs, `busy` is high and the core must stall any read of the result registers until `busy` falls.

The controller has three states. IDLE waits for work, and `start` moves it to CALC. CALC runs one shift-add step per cycle, and after the step for the last bit it moves to SIGN. SIGN applies the sign correction, writes both result registers, and returns to IDLE.

Top module: `mul_hilo`

## Requirements
- R1: After reset, `hi` and `lo` are zero and `busy` is low.
- R2: A `start` seen while `busy` is low raises `busy` in the following cycle.
- R3: With `is_signed` low, both operands are unsigned and the result is their 64-bit product, with bits [31:0] in `lo` and bits [63:32] in `hi`.
- R4: With `is_signed` high, the result is the 64-bit two's-complement product. This includes products of the most negative value, of -1, and of zero.
- R5: `busy` stays high for exactly 33 cycles after each accepted start: 32 shift-add steps plus one sign/write cycle. The new result is visible in the first cycle that `busy` is low.
- R6: While `busy` is high, `hi` and `lo` keep the previous result.
- R7: A `start` while `busy` is high is ignored. The result still comes from the operands captured at the accepted start, and the busy period is not lengthened.
- R8: A `start` in the first cycle after `busy` falls is accepted. In that same cycle `hi` and `lo` still show the result that just completed.
- R9: While idle with `start` low, `hi` and `lo` do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a multiply (accepted only when idle) |
| is_signed | input | 1 | 1: two's-complement operands, 0: unsigned |
| op_a | input | 32 | Multiplicand |
| op_b | input | 32 | Multiplier |
| busy | output | 1 | High while a multiply is in progress |
| hi | output | 32 | Upper half of the last product |
| lo | output | 32 | Lower half of the last product |

## Verification
Two functions can meet in a single cycle: the core reading back a finished result and the same core issuing the next multiply. The bench provokes this by driving `start` on the very first cycle in which `busy` is seen low. In that cycle it judges `hi`/`lo` against the completed product, and it later judges the second product against its own operands. A second collision is a `start` that arrives mid-computation with different operands. This is judged by the result of the first operation and by a busy period of unchanged length.

// File: rtl/mul_pkg.sv
package mul_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CALC = 2'd1,
        ST_SIGN = 2'd2
    } mul_state_e;
endpackage

// File: rtl/mul_ctrl.sv
module mul_ctrl
    import mul_pkg::*;
#(
    parameter int W = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic step,
    output logic fin,
    output logic busy
);
    localparam int CW = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    mul_state_e     state_q, state_d;
    logic [CW-1:0]  cnt_q;

    // state register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (load)
                cnt_q <= '0;
            else if (step)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    // output and transition process
    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        step    = 1'b0;
        fin     = 1'b0;
        busy    = 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                busy = 1'b0;
                if (start) begin
                    load    = 1'b1;
                    state_d = ST_CALC;
                end
            end
            ST_CALC: begin
                step = 1'b1;
                if (cnt_q == LAST)
                    state_d = ST_SIGN;
            end
            ST_SIGN: begin
                fin     = 1'b1;
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/mul_shift_add.sv
module mul_shift_add #(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic           step,
    input  logic           is_signed,
    input  logic [W-1:0]   op_a,
    input  logic [W-1:0]   op_b,
    output logic [2*W-1:0] prod
);
    localparam int PW = 2 * W;

    logic [PW-1:0] mcand_q, acc_q;
    logic [W-1:0]  mplier_q;
    logic          neg_q;

    logic          a_neg, b_neg;
    logic [W-1:0]  mag_a, mag_b;

    always_comb begin
        a_neg = is_signed & op_a[W-1];
        b_neg = is_signed & op_b[W-1];
        mag_a = a_neg ? (~op_a + 1'b1) : op_a;
        mag_b = b_neg ? (~op_b + 1'b1) : op_b;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mcand_q  <= '0;
            acc_q    <= '0;
            mplier_q <= '0;
            neg_q    <= 1'b0;
        end else if (load) begin
            mcand_q  <= {{W{1'b0}}, mag_a};
            mplier_q <= mag_b;
            acc_q    <= '0;
            neg_q    <= a_neg ^ b_neg;
        end else if (step) begin
            if (mplier_q[0])
                acc_q <= acc_q + mcand_q;
            mcand_q  <= mcand_q << 1;
            mplier_q <= mplier_q >> 1;
        end
    end

    assign prod = neg_q ? (~acc_q + 1'b1) : acc_q;
endmodule

// File: rtl/mul_result_regs.sv
module mul_result_regs #(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr,
    input  logic [2*W-1:0] prod,
    output logic [W-1:0]   hi,
    output logic [W-1:0]   lo
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi <= '0;
            lo <= '0;
        end else if (wr) begin
            hi <= prod[2*W-1:W];
            lo <= prod[W-1:0];
        end
    end
endmodule

// File: rtl/mul_hilo.sv
module mul_hilo #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         is_signed,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic         busy,
    output logic [W-1:0] hi,
    output logic [W-1:0] lo
);
    logic           load, step, fin;
    logic [2*W-1:0] prod;

    mul_ctrl #(.W(W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start),
        .load(load), .step(step), .fin(fin), .busy(busy)
    );

    mul_shift_add #(.W(W)) u_dp (
        .clk(clk), .rst_n(rst_n), .load(load), .step(step),
        .is_signed(is_signed), .op_a(op_a), .op_b(op_b), .prod(prod)
    );

    mul_result_regs #(.W(W)) u_res (
        .clk(clk), .rst_n(rst_n), .wr(fin), .prod(prod),
        .hi(hi), .lo(lo)
    );
endmodule

// File: rtl/mul_hilo_chk.sv
module mul_hilo_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         busy,
    input logic [W-1:0] hi,
    input logic [W-1:0] lo
);
    localparam int BW = $clog2(W + 2) + 1;
    localparam logic [BW-1:0] BUSY_LEN = BW'(W + 1);

    logic [BW-1:0] bcnt;

    always_ff @(posedge clk) begin
        if (!rst_n)
            bcnt <= '0;
        else if (busy)
            bcnt <= bcnt + 1'b1;
        else
            bcnt <= '0;
    end

    p_busy_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);

    p_busy_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (bcnt == BUSY_LEN));

    p_hold_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!busy || ($stable(hi) && $stable(lo))));

    p_no_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |-> (bcnt <= BUSY_LEN));

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(hi) && $stable(lo)));
endmodule

bind mul_hilo mul_hilo_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start),
    .busy(busy), .hi(hi), .lo(lo)
);

// File: tb/test_mul_hilo.sv
module test_mul_hilo;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        is_signed = 1'b0;
    logic [31:0] op_a = '0, op_b = '0;
    logic        busy;
    logic [31:0] hi, lo;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    logic [63:0] exp_q[$];
    logic [63:0] last_res = '0;
    int          busy_cnt = 0;
    bit          prev_busy = 0;

    always #5 clk = ~clk;

    mul_hilo i_mul_hilo (
        .clk(clk), .rst_n(rst_n), .start(start), .is_signed(is_signed),
        .op_a(op_a), .op_b(op_b), .busy(busy), .hi(hi), .lo(lo)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] model(input logic [31:0] a, input logic [31:0] b, input bit s);
        longint sa, sb;
        if (s) begin
            sa = longint'($signed(a));
            sb = longint'($signed(b));
            return 64'(sa * sb);
        end
        return {32'b0, a} * {32'b0, b};
    endfunction

    // driver: issue a multiply and push its expected product
    task automatic issue(input logic [31:0] a, input logic [31:0] b, input bit s);
        start = 1'b1; op_a = a; op_b = b; is_signed = s;
        exp_q.push_back(model(a, b, s));
        @(negedge clk);
        start = 1'b0;
        check("R2 busy after start", {63'b0, busy}, 64'd1);
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    // monitor: pop on completion and compare
    always @(negedge clk) begin
        if (rst_n) begin
            if (busy) busy_cnt++;
            if (prev_busy && !busy) begin
                check("R5 busy length", 64'(busy_cnt), 64'd33);
                if (exp_q.size() == 0) begin
                    check("R3/R4 unexpected result", 64'd1, 64'd0);
                end else begin
                    last_res = exp_q.pop_front();
                    check("R3 R4 product", {hi, lo}, last_res);
                end
                busy_cnt = 0;
            end
            prev_busy = busy;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_errors++; n_checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset busy", {63'b0, busy}, 64'd0);
        check("R1 reset hi/lo", {hi, lo}, 64'd0);

        // R9: idle with no start keeps results
        repeat (4) @(negedge clk);
        check("R9 idle hold", {hi, lo}, 64'd0);

        // R3 unsigned cases
        issue(32'd7, 32'd6, 0);                 wait_idle();
        issue(32'hFFFF_FFFF, 32'hFFFF_FFFF, 0); wait_idle();
        issue(32'h8000_0000, 32'd2, 0);         wait_idle();
        // R4 signed cases
        issue(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1); wait_idle();
        issue(32'h8000_0000, 32'h8000_0000, 1); wait_idle();
        issue(32'hFFFF_FFF9, 32'd12345, 1);     wait_idle();
        issue(32'd0, 32'h8000_0000, 1);         wait_idle();
        issue(32'h1234_5678, 32'h9ABC_DEF0, 1); wait_idle();

        // R6: during busy the previous result holds; R7: mid-run start ignored
        issue(32'd1000, 32'd3000, 0);
        repeat (5) @(negedge clk);
        check("R6 hold while busy", {hi, lo}, last_res);
        start = 1'b1; op_a = 32'd9; op_b = 32'd9; is_signed = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R7 still busy", {63'b0, busy}, 64'd1);
        wait_idle();
        @(negedge clk);
        check("R7 no extra run", {63'b0, busy}, 64'd0);

        // R8: back-to-back, start in first idle cycle
        issue(32'hDEAD_BEEF, 32'd3, 0);
        wait_idle();
        check("R8 old result readable", {hi, lo}, model(32'hDEAD_BEEF, 32'd3, 0));
        issue(32'hFFFF_FFFE, 32'd5, 1);
        check("R8 hold at restart", {hi, lo}, model(32'hDEAD_BEEF, 32'd3, 0));
        wait_idle();
        repeat (3) @(negedge clk);
        check("R9 idle hold after run", {hi, lo}, model(32'hFFFF_FFFE, 32'd5, 1));
        check("R3 R4 queue drained", 64'(exp_q.size()), 64'd0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule